// File: doc/BRIEF.md
# Width-Ordered Four-Lane Serial Data Datapath

This block sits between a 32-bit host data register and the data phase of a four-lane serial flash or display link. It has two independent engines. The transmit engine takes one host word and a width code and shifts the selected unit out as a stream of 4-bit symbols. The receive engine collects 4-bit symbols from the lanes and rebuilds a host word under the same width rule.

The width code sets how many bytes one host transaction moves and the order they take on the wire. A byte access moves only the low byte. A half-word access sends the upper byte of the low half first. A word access sends bits 31:24 first and bits 7:0 last. The byte order on the wire therefore runs opposite to little-endian memory order inside each 2-byte or 4-byte unit. Writing and reading at the same width returns the original value. Wider units move more data per host handshake.

Both host-side request interfaces are valid/ready. A request is taken on a rising edge where valid and ready are both high. Ready stays low while that engine has a unit in flight, so the host holds its valid and data until ready returns. The receive result is a one-cycle pulse with no back-pressure: the host must take it in the cycle it appears.

Top module: `qspi_order_dp`

## Requirements
- R1: Width code 0 (byte) sends two symbols: tx_data[7:4], then tx_data[3:0]. tx_data[31:8] has no effect on the lanes.
- R2: Width code 1 (half word) sends four symbols, upper byte first: tx_data[15:12], [11:8], [7:4], [3:0]. tx_data[31:16] has no effect.
- R3: Width code 2 (word) sends eight symbols from tx_data[31:28] down to tx_data[3:0]. Width code 3 behaves exactly like code 2.
- R4: Each symbol drives lane i with bit i of the symbol. The first symbol appears in the cycle after acceptance. lane_out_en is high for exactly the unit's symbol count, in consecutive cycles. tx_ready is low from the cycle after acceptance until the cycle after the last symbol.
- R5: After a receive request is accepted, lane_in is sampled on each of the next N rising edges, where N is 2, 4 or 8 by width code. rx_sample is high in exactly those cycles. The first symbol sampled becomes the most significant symbol of the unit.
- R6: Data sent at one width and looped back into a receive of the same width returns the original low 8, 16 or 32 bits.
- R7: rd_valid is high for exactly one cycle, in the cycle after the last symbol is sampled. In that cycle the bits of rd_data above the unit are zero.
- R8: The transmit and receive engines run concurrently and independently. Each may use a different width.
- R9: A synchronous reset stops both engines and discards a partial receive unit. After reset both ready outputs are high, and lane_out_en, rx_sample and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Transmit request valid |
| tx_ready | output | 1 | Transmit engine can accept a request |
| tx_data | input | 32 | Host word to send |
| tx_width | input | 2 | Transmit width code: 0 byte, 1 half word, 2 or 3 word |
| lane_out | output | 4 | Symbol driven onto the four data lanes |
| lane_out_en | output | 1 | lane_out holds a valid symbol this cycle |
| rx_req_valid | input | 1 | Receive request valid |
| rx_req_ready | output | 1 | Receive engine can accept a request |
| rx_width | input | 2 | Receive width code, same encoding as tx_width |
| lane_in | input | 4 | Symbol read from the four data lanes |
| rx_sample | output | 1 | lane_in is sampled at the end of this cycle |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a completed unit |
| rd_data | output | 32 | Rebuilt host word, zero-extended above the unit |

## Verification
Transmit acceptance and receive acceptance can fall on the same rising edge, since the engines are independent. The bench provokes this on every table vector: it raises both valid inputs in one cycle and loops lane_out back into lane_in. Each symbol is judged on the lanes, and the rebuilt word is checked in the rd_valid cycle. A directed test then overlaps a word transmit with a byte receive fed from bench-driven symbols. It checks that the receive result completes while transmit symbols are still being driven, and that neither engine disturbs the other.

// File: rtl/qob_pkg.sv
package qob_pkg;
  typedef enum logic [1:0] {
    QOB_W8   = 2'd0,
    QOB_W16  = 2'd1,
    QOB_W32  = 2'd2,
    QOB_W32X = 2'd3
  } qob_width_e;
endpackage

// File: rtl/qob_unit_sizer.sv
module qob_unit_sizer
  import qob_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int LANES  = 4,
  localparam int SYMS  = HOST_W / LANES,
  localparam int CW    = $clog2(SYMS + 1),
  localparam int SHW   = $clog2(HOST_W)
) (
  input  qob_width_e     width,
  output logic [CW-1:0]  nsym,
  output logic [SHW-1:0] lshift
);
  int nbytes;

  always_comb begin
    unique case (width)
      QOB_W8:  nbytes = 1;
      QOB_W16: nbytes = 2;
      default: nbytes = 4;
    endcase
    nsym   = CW'((nbytes * 8) / LANES);
    lshift = SHW'(HOST_W - nbytes * 8);
  end
endmodule

// File: rtl/qob_tx_serializer.sv
module qob_tx_serializer
  import qob_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int LANES  = 4,
  localparam int SYMS  = HOST_W / LANES,
  localparam int CW    = $clog2(SYMS + 1),
  localparam int SHW   = $clog2(HOST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HOST_W-1:0] in_data,
  input  qob_width_e        in_width,
  output logic [LANES-1:0]  sym_out,
  output logic              sym_en
);
  logic [HOST_W-1:0] shreg;
  logic [CW-1:0]     left;
  logic [CW-1:0]     nsym;
  logic [SHW-1:0]    lshift;

  qob_unit_sizer #(.HOST_W(HOST_W), .LANES(LANES)) sizer_i (
    .width (in_width),
    .nsym  (nsym),
    .lshift(lshift)
  );

  assign in_ready = (left == '0);
  assign sym_en   = (left != '0);
  assign sym_out  = shreg[HOST_W-1 -: LANES];

  // Left-aligning the unit drops the unused upper host bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      left  <= '0;
    end else if (in_valid && in_ready) begin
      shreg <= in_data << lshift;
      left  <= nsym;
    end else if (left != '0) begin
      shreg <= shreg << LANES;
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/qob_rx_deserializer.sv
module qob_rx_deserializer
  import qob_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int LANES  = 4,
  localparam int SYMS  = HOST_W / LANES,
  localparam int CW    = $clog2(SYMS + 1),
  localparam int SHW   = $clog2(HOST_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  qob_width_e        req_width,
  input  logic [LANES-1:0]  sym_in,
  output logic              sample,
  output logic              out_valid,
  output logic [HOST_W-1:0] out_data
);
  logic [HOST_W-1:0] shreg;
  logic [HOST_W-1:0] next_shreg;
  logic [CW-1:0]     left;
  logic [CW-1:0]     nsym;
  logic [SHW-1:0]    lshift_unused;

  qob_unit_sizer #(.HOST_W(HOST_W), .LANES(LANES)) sizer_i (
    .width (req_width),
    .nsym  (nsym),
    .lshift(lshift_unused)
  );

  assign req_ready  = (left == '0);
  assign sample     = (left != '0);
  assign next_shreg = {shreg[HOST_W-LANES-1:0], sym_in};

  // The shift register is cleared on acceptance, so the result is zero-extended.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (req_valid && req_ready) begin
        shreg <= '0;
        left  <= nsym;
      end else if (left != '0) begin
        shreg <= next_shreg;
        left  <= left - 1'b1;
        if (left == CW'(1)) begin
          out_valid <= 1'b1;
          out_data  <= next_shreg;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_order_dp.sv
module qspi_order_dp
  import qob_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [HOST_W-1:0] tx_data,
  input  logic [1:0]        tx_width,
  output logic [LANES-1:0]  lane_out,
  output logic              lane_out_en,
  input  logic              rx_req_valid,
  output logic              rx_req_ready,
  input  logic [1:0]        rx_width,
  input  logic [LANES-1:0]  lane_in,
  output logic              rx_sample,
  output logic              rd_valid,
  output logic [HOST_W-1:0] rd_data
);
  qob_tx_serializer #(.HOST_W(HOST_W), .LANES(LANES)) tx_i (
    .clk     (clk),
    .rst     (rst),
    .in_valid(tx_valid),
    .in_ready(tx_ready),
    .in_data (tx_data),
    .in_width(qob_width_e'(tx_width)),
    .sym_out (lane_out),
    .sym_en  (lane_out_en)
  );

  qob_rx_deserializer #(.HOST_W(HOST_W), .LANES(LANES)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(rx_req_valid),
    .req_ready(rx_req_ready),
    .req_width(qob_width_e'(rx_width)),
    .sym_in   (lane_in),
    .sample   (rx_sample),
    .out_valid(rd_valid),
    .out_data (rd_data)
  );
endmodule

// File: rtl/qob_checker.sv
module qob_checker #(
  parameter int HOST_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              lane_out_en,
  input logic              rx_req_valid,
  input logic              rx_req_ready,
  input logic [1:0]        rx_width,
  input logic              rx_sample,
  input logic              rd_valid,
  input logic [HOST_W-1:0] rd_data
);
  logic [1:0] rx_w_q;

  always_ff @(posedge clk) begin
    if (rst) rx_w_q <= 2'd0;
    else if (rx_req_valid && rx_req_ready) rx_w_q <= rx_width;
  end

  assert_tx_start_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> lane_out_en);
  assert_tx_busy_R4: assert property (@(posedge clk) disable iff (rst)
    lane_out_en |-> !tx_ready);
  assert_rx_start_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_req_valid && rx_req_ready) |=> rx_sample);
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_rd_zero8_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rx_w_q == 2'd0) |-> (rd_data[HOST_W-1:8] == '0));
  assert_rd_zero16_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rx_w_q == 2'd1) |-> (rd_data[HOST_W-1:16] == '0));
  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_ready && rx_req_ready && !lane_out_en && !rx_sample && !rd_valid));
endmodule

bind qspi_order_dp qob_checker #(.HOST_W(HOST_W), .LANES(LANES)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .lane_out_en (lane_out_en),
  .rx_req_valid(rx_req_valid),
  .rx_req_ready(rx_req_ready),
  .rx_width    (rx_width),
  .rx_sample   (rx_sample),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data)
);

// File: tb/qspi_order_dp_tb.sv
module qspi_order_dp_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tx_valid, tx_ready;
  logic [31:0] tx_data;
  logic [1:0]  tx_width;
  logic [3:0]  lane_out;
  logic        lane_out_en;
  logic        rx_req_valid, rx_req_ready;
  logic [1:0]  rx_width;
  logic [3:0]  lane_in, drv_nib;
  logic        loop_en;
  logic        rx_sample, rd_valid;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign lane_in = loop_en ? lane_out : drv_nib;

  qspi_order_dp dut_i (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_width(tx_width),
    .lane_out(lane_out), .lane_out_en(lane_out_en),
    .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready), .rx_width(rx_width),
    .lane_in(lane_in), .rx_sample(rx_sample), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  localparam int NV = 6;
  localparam logic [1:0]  VW  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1};
  localparam logic [31:0] VD  [NV] = '{32'h11223344, 32'h11223344, 32'h11223344,
                                       32'hA1B2C3D4, 32'hFFFFFF5A, 32'hDEADBEEF};
  localparam logic [31:0] VRX [NV] = '{32'h00000044, 32'h00003344, 32'h11223344,
                                       32'hA1B2C3D4, 32'h0000005A, 32'h0000BEEF};
  localparam int VN [NV] = '{2, 4, 8, 8, 2, 4};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string wreq(input logic [1:0] w);
    if (w == 2'd0) return "R1";
    if (w == 2'd1) return "R2";
    return "R3";
  endfunction

  // Concurrent TX and RX start on one edge, lanes looped back (R6, R8).
  task automatic run_vec(input int k);
    int n;
    logic [3:0] en;
    n = VN[k];
    @(negedge clk);
    loop_en = 1; tx_valid = 1; tx_data = VD[k]; tx_width = VW[k];
    rx_req_valid = 1; rx_width = VW[k];
    chk(tx_ready && rx_req_ready, "R4", {30'd0, tx_ready, rx_req_ready}, 32'd3);
    @(negedge clk);
    tx_valid = 0; rx_req_valid = 0;
    for (int i = 0; i < n; i++) begin
      en = 4'(VRX[k] >> (4 * (n - 1 - i)));
      chk(lane_out_en && lane_out == en, wreq(VW[k]), {27'd0, lane_out_en, lane_out}, {27'd1, en});
      chk(!tx_ready && rx_sample, "R5", {30'd0, tx_ready, rx_sample}, 32'd1);
      @(negedge clk);
    end
    chk(!lane_out_en && tx_ready, "R4", {30'd0, lane_out_en, tx_ready}, 32'd1);
    chk(rd_valid && rd_data == VRX[k], "R6", rd_data, VRX[k]);
    @(negedge clk);
    chk(!rd_valid && !rx_sample, "R7", {30'd0, rd_valid, rx_sample}, 32'd0);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; tx_valid = 0; rx_req_valid = 0; tx_data = '0; tx_width = '0;
    rx_width = '0; loop_en = 0; drv_nib = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_ready && rx_req_ready && !lane_out_en && !rx_sample && !rd_valid, "R9",
        {27'd0, tx_ready, rx_req_ready, lane_out_en, rx_sample, rd_valid}, 32'h18);

    for (int k = 0; k < NV; k++) run_vec(k);

    // R5: bench-driven symbols, half word, first symbol is most significant.
    @(negedge clk);
    loop_en = 0; rx_req_valid = 1; rx_width = 2'd1;
    @(negedge clk);
    rx_req_valid = 0;
    for (int i = 0; i < 4; i++) begin
      drv_nib = (i == 0) ? 4'hC : (i == 1) ? 4'h0 : (i == 2) ? 4'hF : 4'hE;
      @(negedge clk);
    end
    chk(rd_valid && rd_data == 32'h0000C0FE, "R5", rd_data, 32'h0000C0FE);

    // R8: word transmit overlapped with byte receive from driven symbols.
    @(negedge clk);
    tx_valid = 1; tx_data = 32'h12345678; tx_width = 2'd2;
    rx_req_valid = 1; rx_width = 2'd0;
    @(negedge clk);
    tx_valid = 0; rx_req_valid = 0; drv_nib = 4'h7;
    chk(lane_out == 4'h1 && lane_out_en, "R8", {28'd0, lane_out}, 32'h1);
    @(negedge clk);
    drv_nib = 4'hE;
    chk(lane_out == 4'h2, "R8", {28'd0, lane_out}, 32'h2);
    @(negedge clk);
    chk(rd_valid && rd_data == 32'h7E, "R8", rd_data, 32'h7E);
    chk(lane_out_en && lane_out == 4'h3, "R8", {28'd0, lane_out}, 32'h3);
    @(negedge clk);
    chk(!rd_valid && rx_req_ready && !tx_ready, "R7", {29'd0, rd_valid, rx_req_ready, tx_ready}, 32'h2);
    repeat (6) @(negedge clk);
    chk(tx_ready && !lane_out_en, "R4", {30'd0, tx_ready, lane_out_en}, 32'h2);

    // R9: reset in the middle of a word receive discards the partial unit.
    rx_req_valid = 1; rx_width = 2'd2; drv_nib = 4'h9;
    @(negedge clk);
    rx_req_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rx_req_ready && !rx_sample, "R9", {30'd0, rx_req_ready, rx_sample}, 32'h2);
    for (int i = 0; i < 8; i++) begin
      chk(!rd_valid, "R9", {31'd0, rd_valid}, 32'd0);
      @(negedge clk);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule